// File: doc/BRIEF.md
# Region-Based I/O Wait-State Generator

This block sits between a processor core and a small external I/O bus of 2048 sixteen-bit locations. The core issues single read or write requests. The block drives a select line, a read strobe and a write strobe, and it also drives the bus address and write data. It returns a one-cycle `done` to the core when the access ends. Only the low eleven address lines carry the I/O address. The three upper lines of the 14-bit external address are held at zero.

The I/O space is split into four fixed regions of 512 words, selected by address bits 10:9. Each region has its own 3-bit wait-state register, so an access can stretch by 0 to 7 extra cycles. The hardware takes the register value at the start of every access. The core writes the registers through a small write-only port, and all of them reset to the slowest setting of 7. Only one access is in flight at a time. A new request is taken only in a cycle after the previous access has ended.

Top module: `io_waitgen`

## Requirements
- R1: After reset, `io_sel`, `io_rd`, `io_wr`, `done` and `bus_addr` are all zero. All four wait registers hold 7, so an access to any region keeps its strobes up for 8 cycles.
- R2: The wait count for an access comes from the register indexed by request address bits 10:9 at acceptance. Register 0 covers 0x000–0x1FF, 1 covers 0x200–0x3FF, 2 covers 0x400–0x5FF and 3 covers 0x600–0x7FF.
- R3: With selected wait value N, the select and the active strobe stay high for exactly N+1 consecutive cycles. `done` is high only in the last of those cycles.
- R4: While an access is active, `bus_addr[10:0]` equals the request address and `bus_addr[13:11]` is zero. The address holds steady for the whole access.
- R5: A read (`req_write`=0) raises `io_rd` and never `io_wr`. The `bus_rdata` value present in the `done` cycle appears on `rd_data` from the next cycle onward, and it stays there until the next read completes.
- R6: A write (`req_write`=1) raises `io_wr` and `bus_oe`, never `io_rd`, and drives `bus_wdata` with the request data throughout the access.
- R7: A request presented while an access is active is ignored. No further access follows the current one.
- R8: A register write (`cfg_we`, index `cfg_sel`, value `cfg_wdata`) during an access leaves that access's length unchanged. The new value takes effect on the next access to that region.
- R9: `io_sel` is high exactly when one of `io_rd` and `io_wr` is high, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core access request, sampled when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | I/O word address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | High in the final cycle of an access |
| rd_data | output | 16 | Data captured from the last completed read |
| cfg_we | input | 1 | Wait register write enable |
| cfg_sel | input | 2 | Wait register index (region) |
| cfg_wdata | input | 3 | New wait value |
| io_sel | output | 1 | I/O space select, active high |
| io_rd | output | 1 | Read strobe, active high |
| io_wr | output | 1 | Write strobe, active high |
| bus_oe | output | 1 | Data bus output enable during writes |
| bus_addr | output | 14 | External address, upper 3 bits zero |
| bus_wdata | output | 16 | Write data to the bus |
| bus_rdata | input | 16 | Read data from the bus |

## Verification
A request sampled at clock edge k puts the select and strobe up after that edge. They stay up for N+1 cycles, and `done` comes with the last of them. The captured read data is due one edge after `done`. The bench drives and samples on falling edges. For each access it counts the consecutive samples with `io_sel` high and checks that `done` is seen only in the last one. It reads `rd_data` at the first sample after the strobes drop. Every region is swept with every wait value, for both reads and writes. The expected length and data come from the value written and a fixed arithmetic pattern on the address.

// File: rtl/iowg_pkg.sv
package iowg_pkg;
    parameter int unsigned ADDR_W     = 11;
    parameter int unsigned EXT_ADDR_W = 14;
    parameter int unsigned DATA_W     = 16;
    parameter int unsigned WAIT_W     = 3;
    parameter int unsigned REGION_CNT = 4;
    localparam int unsigned REGION_W  = $clog2(REGION_CNT);
    localparam int unsigned PAD_W     = EXT_ADDR_W - ADDR_W;

    typedef logic [ADDR_W-1:0]   io_addr_t;
    typedef logic [DATA_W-1:0]   io_data_t;
    typedef logic [WAIT_W-1:0]   wait_t;
    typedef logic [REGION_W-1:0] region_t;

    typedef enum logic {PH_IDLE = 1'b0, PH_ACTIVE = 1'b1} phase_t;

    typedef struct packed {
        io_addr_t addr;
        logic     write;
        io_data_t wdata;
    } iowg_acc_t;

    function automatic region_t region_of(io_addr_t a);
        return a[ADDR_W-1 -: REGION_W];
    endfunction
endpackage

// File: rtl/iowg_waitregs.sv
module iowg_waitregs
    import iowg_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cfg_we,
    input  region_t                          cfg_sel,
    input  wait_t                            cfg_wdata,
    output logic [REGION_CNT-1:0][WAIT_W-1:0] waits
);
    localparam wait_t SLOWEST = wait_t'((1 << WAIT_W) - 1);

    for (genvar g = 0; g < REGION_CNT; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                waits[g] <= SLOWEST;
            end else if (cfg_we && (cfg_sel == region_t'(g))) begin
                waits[g] <= cfg_wdata;
            end
        end
    end
endmodule

// File: rtl/iowg_select.sv
module iowg_select
    import iowg_pkg::*;
(
    input  logic [REGION_CNT-1:0][WAIT_W-1:0] waits,
    input  io_addr_t                          addr,
    output wait_t                             sel_wait
);
    always_comb begin
        sel_wait = waits[region_of(addr)];
    end
endmodule

// File: rtl/iowg_seq.sv
module iowg_seq
    import iowg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  logic      req_write,
    input  io_addr_t  req_addr,
    input  io_data_t  req_wdata,
    input  wait_t     sel_wait,
    output iowg_acc_t acc,
    output logic      active,
    output logic      last
);
    phase_t phase;
    wait_t  remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            remain <= '0;
            acc    <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        acc.addr  <= req_addr;
                        acc.write <= req_write;
                        acc.wdata <= req_wdata;
                        remain    <= sel_wait;
                        phase     <= PH_ACTIVE;
                    end
                end
                PH_ACTIVE: begin
                    if (remain == '0) begin
                        phase <= PH_IDLE;
                    end else begin
                        remain <= remain - wait_t'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        active = (phase == PH_ACTIVE);
        last   = active && (remain == '0);
    end
endmodule

// File: rtl/iowg_bus.sv
module iowg_bus
    import iowg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  iowg_acc_t             acc,
    input  logic                  active,
    input  logic                  last,
    input  io_data_t              bus_rdata,
    output logic                  io_sel,
    output logic                  io_rd,
    output logic                  io_wr,
    output logic                  bus_oe,
    output logic [EXT_ADDR_W-1:0] bus_addr,
    output io_data_t              bus_wdata,
    output logic                  done,
    output io_data_t              rd_data
);
    always_comb begin
        io_sel    = active;
        io_rd     = active && !acc.write;
        io_wr     = active && acc.write;
        bus_oe    = io_wr;
        bus_addr  = active ? {{PAD_W{1'b0}}, acc.addr} : '0;
        bus_wdata = io_wr ? acc.wdata : '0;
        done      = last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (last && !acc.write) begin
            rd_data <= bus_rdata;
        end
    end
endmodule

// File: rtl/io_waitgen.sv
module io_waitgen
    import iowg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [10:0] req_addr,
    input  logic [15:0] req_wdata,
    output logic        done,
    output logic [15:0] rd_data,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [2:0]  cfg_wdata,
    output logic        io_sel,
    output logic        io_rd,
    output logic        io_wr,
    output logic        bus_oe,
    output logic [13:0] bus_addr,
    output logic [15:0] bus_wdata,
    input  logic [15:0] bus_rdata
);
    logic [REGION_CNT-1:0][WAIT_W-1:0] waits;
    wait_t     sel_wait;
    iowg_acc_t acc;
    logic      active;
    logic      last;

    iowg_waitregs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .waits     (waits)
    );

    iowg_select u_sel (
        .waits    (waits),
        .addr     (req_addr),
        .sel_wait (sel_wait)
    );

    iowg_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .sel_wait  (sel_wait),
        .acc       (acc),
        .active    (active),
        .last      (last)
    );

    iowg_bus u_bus (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .active    (active),
        .last      (last),
        .bus_rdata (bus_rdata),
        .io_sel    (io_sel),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .bus_oe    (bus_oe),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .done      (done),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/iowg_chk.sv
module iowg_chk (
    input logic        clk,
    input logic        rst,
    input logic        done,
    input logic        io_sel,
    input logic        io_rd,
    input logic        io_wr,
    input logic        bus_oe,
    input logic [13:0] bus_addr
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> !io_sel && !done);

    // R3
    done_in_access_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> io_sel);

    // R3
    done_ends_access_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !io_sel);

    // R3
    no_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (io_sel && !done) |=> io_sel);

    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        io_sel |-> (bus_addr[13:11] == 3'b000));

    // R4
    addr_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (io_sel && !done) |=> $stable(bus_addr));

    // R6
    write_drive_chk: assert property (@(posedge clk) disable iff (rst)
        io_wr |-> bus_oe);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({io_rd, io_wr}) && ((io_rd || io_wr) == io_sel));
endmodule

bind io_waitgen iowg_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .io_sel   (io_sel),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .bus_oe   (bus_oe),
    .bus_addr (bus_addr)
);

// File: tb/io_waitgen_tb_top.sv
module io_waitgen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [10:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rd_data;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [2:0]  cfg_wdata = '0;
    logic        io_sel, io_rd, io_wr, bus_oe;
    logic [13:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    assign bus_rdata = {5'b10101, bus_addr[10:0]} ^ 16'h3c00;

    io_waitgen dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .io_sel(io_sel), .io_rd(io_rd), .io_wr(io_wr), .bus_oe(bus_oe),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg(input int r, input int v);
        cfg_we = 1'b1; cfg_sel = 2'(r); cfg_wdata = 3'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Runs one access; optional mid-access config write at first active sample.
    task automatic access(input bit wr, input logic [10:0] a, input logic [15:0] d,
                          input int exp_len, input bit mid_cfg, input int mr, input int mv,
                          input bit mid_req);
        int  len = 0;
        int  done_at = -1;
        int  done_cnt = 0;
        bit  addr_ok = 1'b1;
        bit  strb_ok = 1'b1;
        bit  wd_ok = 1'b1;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (io_sel && len < 20) begin
            len++;
            if (done) begin done_at = len; done_cnt++; end
            if (bus_addr != {3'b000, a}) addr_ok = 1'b0;
            if (wr ? (!io_wr || io_rd || !bus_oe) : (!io_rd || io_wr)) strb_ok = 1'b0;
            if (wr && bus_wdata != d) wd_ok = 1'b0;
            if (len == 1 && mid_cfg) begin
                cfg_we = 1'b1; cfg_sel = 2'(mr); cfg_wdata = 3'(mv);
            end else begin
                cfg_we = 1'b0;
            end
            if (len == 2 && mid_req) begin
                req_valid = 1'b1; req_write = ~wr; req_addr = a ^ 11'h155;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        cfg_we = 1'b0; req_valid = 1'b0;
        // R2 R3: length of strobe window
        check(len == exp_len, "R2/R3 strobe length", len, exp_len);
        // R3: done exactly once, in last cycle
        check(done_cnt == 1 && done_at == exp_len, "R3 done position", done_at, exp_len);
        // R4
        check(addr_ok, "R4 bus address", 0, 1);
        // R9 with R5/R6 strobe polarity
        check(strb_ok, wr ? "R6 write strobes" : "R5 read strobes", 0, 1);
        if (wr) check(wd_ok, "R6 write data", 0, 1);
        else check(rd_data == ({5'b10101, a} ^ 16'h3c00), "R5 read data",
                   int'(rd_data), int'({5'b10101, a} ^ 16'h3c00));
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(!io_sel && !io_rd && !io_wr && !done, "R1 idle strobes", int'(io_sel), 0);
        check(bus_addr == 14'd0, "R1 idle address", int'(bus_addr), 0);
        // R1: defaults of 7 -> 8-cycle accesses in every region
        for (int r = 0; r < 4; r++)
            access(1'b0, 11'(r * 512 + 3), 16'h0, 8, 1'b0, 0, 0, 1'b0);
        // R2 R3 R5 R6: full sweep of region x wait value x direction
        for (int r = 0; r < 4; r++) begin
            for (int n = 0; n < 8; n++) begin
                cfg(r, n);
                access(1'b0, 11'(r * 512 + (n * 37 + r * 5) % 512), 16'h0,
                       n + 1, 1'b0, 0, 0, 1'b0);
                access(1'b1, 11'(r * 512 + (n * 61 + 511 - r) % 512),
                       16'(16'hbeef ^ (n << 4) ^ r), n + 1, 1'b0, 0, 0, 1'b0);
            end
        end
        // R2: other regions unaffected by one region's setting
        cfg(0, 1); cfg(1, 4); cfg(2, 0); cfg(3, 6);
        access(1'b0, 11'h1ff, 16'h0, 2, 1'b0, 0, 0, 1'b0);
        access(1'b0, 11'h200, 16'h0, 5, 1'b0, 0, 0, 1'b0);
        access(1'b1, 11'h5ff, 16'h1234, 1, 1'b0, 0, 0, 1'b0);
        access(1'b0, 11'h600, 16'h0, 7, 1'b0, 0, 0, 1'b0);
        // R8: config write mid-access affects only the next access
        cfg(1, 2);
        access(1'b0, 11'h2a0, 16'h0, 3, 1'b1, 1, 6, 1'b0);
        access(1'b0, 11'h2a1, 16'h0, 7, 1'b0, 0, 0, 1'b0);
        // R7: request during busy is ignored
        cfg(2, 5);
        access(1'b1, 11'h444, 16'h5a5a, 6, 1'b0, 0, 0, 1'b1);
        begin
            int extra = 0;
            for (int i = 0; i < 4; i++) begin
                if (io_sel) extra++;
                @(negedge clk);
            end
            check(extra == 0, "R7 ignored request", extra, 0);
        end
        // R5: read data held across a write
        access(1'b0, 11'h0a5, 16'h0, 2, 1'b0, 0, 0, 1'b0);
        access(1'b1, 11'h0a6, 16'hffff, 2, 1'b0, 0, 0, 1'b0);
        check(rd_data == ({5'b10101, 11'h0a5} ^ 16'h3c00), "R5 read data held",
              int'(rd_data), int'({5'b10101, 11'h0a5} ^ 16'h3c00));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule